// File: doc/BRIEF.md
# Ring Counter with Compare Outputs

This block is a 32-bit up/down event counter for a motion-control or pulse-measurement subsystem. Three external pins feed it: an up strobe, a down strobe and a preset strobe. Each pin passes through a synchronizer. Each rising edge of the synchronized level is one event. The count runs in one of two ranges, picked by the low bit of the mode word:

- In the wide range the count is a 32-bit two's-complement value that wraps between the signed extremes.
- In the narrow range the count is unsigned and wraps inside a programmable ring.

While counting, the block keeps the largest and smallest values the count has held. Two compare channels each raise a sticky output when the count equals their compare value. A channel's output drops only when a command clears it.

Software reaches the block through a flat array of 16-bit words. A write takes effect on the clock edge where `reg_wr` is high. The read data is combinational from `reg_addr`. Every 32-bit quantity uses two consecutive addresses, with the low word at the even address. The word map is:

| Address | Word |
|---|---|
| 0 | mode (0 to 11) |
| 1 | command pulses |
| 2/3 | ring length |
| 4/5 | preset data |
| 6/7 | compare A |
| 8/9 | compare B |
| 10/11 | count |
| 12/13 | maximum |
| 14/15 | minimum |
| 16 | compare flags |
| 17 | pin levels |
| 18 | identification |

Writing any legal mode value returns the rest of the block to its power-up contents.

Top module: `ring_cmp_counter`

## Requirements
- R1: After reset the following values hold:
  - count, maximum and minimum read 0;
  - both compare outputs are low;
  - the ring length reads 0x0000 (low word) and 0x0001 (high word);
  - both compare values read 32767;
  - preset data reads 0;
  - address 18 reads 4010.
- R2: Each rising edge of the synchronized up pin adds one to the count, and each rising edge of the synchronized down pin subtracts one. The count changes on the third clock edge after the pin rises. Up and down edges in the same cycle leave the count unchanged.
- R3: In the wide range (mode bit 0 = 0), an up step from 0x7FFFFFFF gives 0x80000000, and a down step from 0x80000000 gives 0x7FFFFFFF.
- R4: In the narrow range (mode bit 0 = 1), the top value is the effective ring length minus one. The effective ring length is the programmed length, except that 0 counts as 1 and anything above 65536 counts as 65536. An up step from the top value or above gives 0, and a down step from 0 gives the top value.
- R5: The count loads the preset data on either of two triggers:
  - a synchronized rising edge of the preset pin;
  - a command write with bit 0 set.
  A preset wins over an up or down edge in the same cycle.
- R6: Writing the count's low word (address 10) or high word (address 11) replaces that half of the count and leaves the other half unchanged.
- R7: The maximum and minimum registers follow the count as signed 32-bit values. In every cycle in which the count changes, the maximum takes the new count if the new count is larger, and the minimum takes it if it is smaller.
- R8: Compare output i goes high one cycle after the count equals compare value i. It stays high after the count moves away.
- R9: A command write clears compare output A when bit 1 is set and compare output B when bit 2 is set. Each bit clears only its own channel.
- R10: Writing a mode value from 0 to 11 stores it and returns every other register, the count and both compare outputs to their reset values. A mode value above 11 is ignored and the stored mode is kept.
- R11: Address 16 reads the compare outputs, with A in bit 0 and B in bit 1. Address 17 reads the synchronized pin levels, with up in bit 0, down in bit 1 and preset in bit 2.
- R12: Unmapped addresses (19 to 31) read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_pin | input | 1 | Asynchronous up strobe |
| dn_pin | input | 1 | Asynchronous down strobe |
| pre_pin | input | 1 | Asynchronous preset strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| cmp_hit | output | 2 | Sticky compare outputs, bit 0 = A, bit 1 = B |

## Verification
A wrong wrap decision or wrong step direction shows on the count words three cycles after the pin edge that caused it. It also leaks into the maximum or minimum words in the same cycle, and those keep the error even after the count is rewritten. A compare flag that is set or cleared wrongly is visible on `cmp_hit` one cycle after the offending count or command, and it persists because the flag is sticky. A missed default reload after a mode write stays visible in the readback of any configuration word until that word is written again.

// File: rtl/rcc_pkg.sv
// Package: shared widths, word addresses and reset values for the ring
// counter. Assumes 16-bit register words and a 32-bit count.
package rcc_pkg;
    localparam int WORD_W = 16;
    localparam int CNT_W  = 2 * WORD_W;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_MODE    = 5'd0;
    localparam logic [ADDR_W-1:0] A_CMD     = 5'd1;
    localparam logic [ADDR_W-1:0] A_RING_LO = 5'd2;
    localparam logic [ADDR_W-1:0] A_RING_HI = 5'd3;
    localparam logic [ADDR_W-1:0] A_PRE_LO  = 5'd4;
    localparam logic [ADDR_W-1:0] A_PRE_HI  = 5'd5;
    localparam logic [ADDR_W-1:0] A_CMP0_LO = 5'd6;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 5'd10;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 5'd11;
    localparam logic [ADDR_W-1:0] A_MAX_LO  = 5'd12;
    localparam logic [ADDR_W-1:0] A_MAX_HI  = 5'd13;
    localparam logic [ADDR_W-1:0] A_MIN_LO  = 5'd14;
    localparam logic [ADDR_W-1:0] A_MIN_HI  = 5'd15;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 5'd16;
    localparam logic [ADDR_W-1:0] A_PINS    = 5'd17;
    localparam logic [ADDR_W-1:0] A_IDENT   = 5'd18;

    localparam logic [WORD_W-1:0] IDENT_VAL = 16'd4010;
    localparam logic [WORD_W-1:0] MODE_MAX  = 16'd11;
    localparam logic [CNT_W-1:0]  RING_DEF  = 32'd65536;
    localparam logic [CNT_W-1:0]  CMP_DEF   = 32'd32767;
    localparam logic [CNT_W-1:0]  PRE_DEF   = '0;

    // Word address of compare channel i, low (hi=0) or high (hi=1) half.
    function automatic logic [ADDR_W-1:0] cmp_addr(input int i, input int hi);
        return ADDR_W'(int'(A_CMP0_LO) + 2 * i + hi);
    endfunction
endpackage

// File: rtl/rcc_sync.sv
// Module: multi-stage synchronizer with rising-edge detect for N pins.
// Assumes STAGES >= 2; each pin is an independent asynchronous level.
module rcc_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] sh;
        logic              prev;
        // Shift the pin through the chain and remember the last level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[STAGES-2:0], pin[g]};
                prev <= sh[STAGES-1];
            end
        end
        assign lvl[g]  = sh[STAGES-1];
        assign rise[g] = sh[STAGES-1] & ~prev;
    end
endmodule

// File: rtl/rcc_core.sv
// Module: count register with priority loads and range-dependent wrap.
// Assumes the load controls are one-hot or idle in any given cycle,
// apart from a preset, which may coincide with a step.
module rcc_core
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dflt,
    input  logic              narrow,
    input  logic [CNT_W-1:0]  ring,
    input  logic              pre_ld,
    input  logic [CNT_W-1:0]  pre_val,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              up,
    input  logic              dn,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_nxt,
    output logic              chg
);
    localparam logic [CNT_W-1:0] RING_MAX = CNT_W'(1) << WORD_W;

    logic [CNT_W-1:0] ring_eff, top, inc_v, dec_v;

    // Clamp the ring length and derive the narrow-range top value.
    always_comb begin
        if (ring == '0)            ring_eff = CNT_W'(1);
        else if (ring > RING_MAX)  ring_eff = RING_MAX;
        else                       ring_eff = ring;
        top = ring_eff - CNT_W'(1);
    end

    // Next value for an up step and for a down step in either range.
    always_comb begin
        if (narrow) begin
            inc_v = (cnt_q >= top) ? '0 : cnt_q + CNT_W'(1);
            dec_v = (cnt_q == '0) ? top : cnt_q - CNT_W'(1);
        end else begin
            inc_v = cnt_q + CNT_W'(1);
            dec_v = cnt_q - CNT_W'(1);
        end
    end

    // Choose the next count: defaults, preset, word write, then step.
    always_comb begin
        cnt_nxt = cnt_q;
        if (dflt)                 cnt_nxt = '0;
        else if (pre_ld)          cnt_nxt = pre_val;
        else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_nxt[WORD_W-1:0]     = wdata;
            if (wr_hi) cnt_nxt[CNT_W-1:WORD_W] = wdata;
        end
        else if (up && !dn)       cnt_nxt = inc_v;
        else if (dn && !up)       cnt_nxt = dec_v;
        chg = (cnt_nxt != cnt_q);
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    logic quiet;
    assign quiet = !dflt && !pre_ld && !wr_lo && !wr_hi;

    a_r3_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !narrow && up && !dn && cnt_q == 32'h7FFF_FFFF) |=> cnt_q == 32'h8000_0000);
    a_r3_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !narrow && dn && !up && cnt_q == 32'h8000_0000) |=> cnt_q == 32'h7FFF_FFFF);
    a_r4_top_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && narrow && up && !dn && cnt_q == top) |=> cnt_q == '0);
    a_r2_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && up && dn) |=> $stable(cnt_q));
    a_r5_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflt && pre_ld) |=> cnt_q == $past(pre_val));
endmodule

// File: rtl/rcc_track.sv
// Module: running signed maximum and minimum of the count.
// Assumes cnt_nxt/chg describe the value the count takes at the next edge.
module rcc_track
    import rcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dflt,
    input  logic              chg,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic              wr_max_lo,
    input  logic              wr_max_hi,
    input  logic              wr_min_lo,
    input  logic              wr_min_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  max_q,
    output logic [CNT_W-1:0]  min_q
);
    // Update the maximum from writes or a larger new count.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt)  max_q <= '0;
        else if (wr_max_lo)  max_q[WORD_W-1:0] <= wdata;
        else if (wr_max_hi)  max_q[CNT_W-1:WORD_W] <= wdata;
        else if (chg && ($signed(cnt_nxt) > $signed(max_q))) max_q <= cnt_nxt;
    end

    // Update the minimum from writes or a smaller new count.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt)  min_q <= '0;
        else if (wr_min_lo)  min_q[WORD_W-1:0] <= wdata;
        else if (wr_min_hi)  min_q[CNT_W-1:WORD_W] <= wdata;
        else if (chg && ($signed(cnt_nxt) < $signed(min_q))) min_q <= cnt_nxt;
    end

    a_r7_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflt && chg && !wr_max_lo && !wr_max_hi) |=> $signed(max_q) >= $signed($past(cnt_nxt)));
    a_r7_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!dflt && chg && !wr_min_lo && !wr_min_hi) |=> $signed(min_q) <= $signed($past(cnt_nxt)));
endmodule

// File: rtl/rcc_cmp.sv
// Module: one compare channel with a sticky hit flag.
// Assumes clear and default commands are single-cycle pulses.
module rcc_cmp
    import rcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dflt,
    input  logic             clr,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] val,
    output logic             hit
);
    // Set on equality, hold until cleared; clear beats a match.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt) hit <= 1'b0;
        else if (clr)       hit <= 1'b0;
        else if (cnt == val) hit <= 1'b1;
    end

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hit);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr && !dflt) |=> hit);
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !dflt && cnt == val) |=> hit);
endmodule

// File: rtl/ring_cmp_counter.sv
// Module: top of the ring counter. Holds the configuration words, decodes
// register writes and commands, and muxes read data.
// Assumes one register access per cycle and NUM_CMP <= 2 for the word map.
module ring_cmp_counter
    import rcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_CMP     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_pin,
    input  logic              dn_pin,
    input  logic              pre_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [NUM_CMP-1:0] cmp_hit
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   lvl, rise;
    logic [3:0]        mode_q;
    logic [CNT_W-1:0]  ring_q, pre_q, cnt_q, cnt_nxt, max_q, min_q;
    logic [CNT_W-1:0]  cmp_val_q [NUM_CMP];
    logic              chg, dflt, cmd_wr, pre_ld;
    logic [NUM_CMP-1:0] clr;

    rcc_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin({pre_pin, dn_pin, up_pin}),
        .lvl(lvl), .rise(rise)
    );

    // Decode mode writes (defaults reload) and command pulses.
    always_comb begin
        dflt   = reg_wr && (reg_addr == A_MODE) && (reg_wdata <= MODE_MAX);
        cmd_wr = reg_wr && (reg_addr == A_CMD);
        pre_ld = rise[2] || (cmd_wr && reg_wdata[0]);
    end

    // Hold the mode word.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode_q <= '0;
        else if (dflt) mode_q <= reg_wdata[3:0];
    end

    // Hold the ring length.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt) ring_q <= RING_DEF;
        else if (reg_wr && reg_addr == A_RING_LO) ring_q[WORD_W-1:0] <= reg_wdata;
        else if (reg_wr && reg_addr == A_RING_HI) ring_q[CNT_W-1:WORD_W] <= reg_wdata;
    end

    // Hold the preset data.
    always_ff @(posedge clk) begin
        if (!rst_n || dflt) pre_q <= PRE_DEF;
        else if (reg_wr && reg_addr == A_PRE_LO) pre_q[WORD_W-1:0] <= reg_wdata;
        else if (reg_wr && reg_addr == A_PRE_HI) pre_q[CNT_W-1:WORD_W] <= reg_wdata;
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        // Hold compare value i.
        always_ff @(posedge clk) begin
            if (!rst_n || dflt) cmp_val_q[i] <= CMP_DEF;
            else if (reg_wr && reg_addr == cmp_addr(i, 0)) cmp_val_q[i][WORD_W-1:0] <= reg_wdata;
            else if (reg_wr && reg_addr == cmp_addr(i, 1)) cmp_val_q[i][CNT_W-1:WORD_W] <= reg_wdata;
        end
        assign clr[i] = cmd_wr && reg_wdata[1+i];

        rcc_cmp u_cmp (
            .clk(clk), .rst_n(rst_n), .dflt(dflt), .clr(clr[i]),
            .cnt(cnt_q), .val(cmp_val_q[i]), .hit(cmp_hit[i])
        );
    end

    rcc_core u_core (
        .clk(clk), .rst_n(rst_n), .dflt(dflt), .narrow(mode_q[0]),
        .ring(ring_q), .pre_ld(pre_ld), .pre_val(pre_q),
        .wr_lo(reg_wr && reg_addr == A_CNT_LO),
        .wr_hi(reg_wr && reg_addr == A_CNT_HI),
        .wdata(reg_wdata), .up(rise[0]), .dn(rise[1]),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .chg(chg)
    );

    rcc_track u_track (
        .clk(clk), .rst_n(rst_n), .dflt(dflt), .chg(chg), .cnt_nxt(cnt_nxt),
        .wr_max_lo(reg_wr && reg_addr == A_MAX_LO),
        .wr_max_hi(reg_wr && reg_addr == A_MAX_HI),
        .wr_min_lo(reg_wr && reg_addr == A_MIN_LO),
        .wr_min_hi(reg_wr && reg_addr == A_MIN_HI),
        .wdata(reg_wdata), .max_q(max_q), .min_q(min_q)
    );

    // Return the word selected by reg_addr; unmapped words read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_MODE:    reg_rdata = WORD_W'(mode_q);
            A_RING_LO: reg_rdata = ring_q[WORD_W-1:0];
            A_RING_HI: reg_rdata = ring_q[CNT_W-1:WORD_W];
            A_PRE_LO:  reg_rdata = pre_q[WORD_W-1:0];
            A_PRE_HI:  reg_rdata = pre_q[CNT_W-1:WORD_W];
            A_CNT_LO:  reg_rdata = cnt_q[WORD_W-1:0];
            A_CNT_HI:  reg_rdata = cnt_q[CNT_W-1:WORD_W];
            A_MAX_LO:  reg_rdata = max_q[WORD_W-1:0];
            A_MAX_HI:  reg_rdata = max_q[CNT_W-1:WORD_W];
            A_MIN_LO:  reg_rdata = min_q[WORD_W-1:0];
            A_MIN_HI:  reg_rdata = min_q[CNT_W-1:WORD_W];
            A_FLAGS:   reg_rdata = WORD_W'(cmp_hit);
            A_PINS:    reg_rdata = WORD_W'(lvl);
            A_IDENT:   reg_rdata = IDENT_VAL;
            default:   reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CMP; i++) begin
            if (reg_addr == cmp_addr(i, 0)) reg_rdata = cmp_val_q[i][WORD_W-1:0];
            if (reg_addr == cmp_addr(i, 1)) reg_rdata = cmp_val_q[i][CNT_W-1:WORD_W];
        end
    end

    a_r10_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        dflt |=> (ring_q == RING_DEF && pre_q == PRE_DEF && cnt_q == '0 && cmp_hit == '0));
    a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_MODE && reg_wdata > MODE_MAX) |=> $stable(mode_q));
endmodule

// File: tb/ring_cmp_counter_tb.sv
module ring_cmp_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_pin = 1'b0, dn_pin = 1'b0, pre_pin = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  cmp_hit;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    ring_cmp_counter u_dut (
        .clk(clk), .rst_n(rst_n), .up_pin(up_pin), .dn_pin(dn_pin),
        .pre_pin(pre_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_hit(cmp_hit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd32(input logic [4:0] a, output logic [31:0] d);
        logic [15:0] lo, hi;
        rd(a, lo);
        rd(a + 5'd1, hi);
        d = {hi, lo};
    endtask

    task automatic pulse(input bit u, input bit d, input bit p);
        @(negedge clk);
        up_pin = u; dn_pin = d; pre_pin = p;
        repeat (3) @(negedge clk);
        up_pin = 0; dn_pin = 0; pre_pin = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v; logic [15:0] w;
        rd32(10, v); check("R1 count", v, 0);
        rd32(12, v); check("R1 max", v, 0);
        rd32(14, v); check("R1 min", v, 0);
        rd32(2, v);  check("R1 ring", v, 32'h0001_0000);
        rd32(6, v);  check("R1 cmpA", v, 32767);
        rd32(8, v);  check("R1 cmpB", v, 32767);
        rd32(4, v);  check("R1 preset", v, 0);
        rd(18, w);   check("R1 ident", w, 4010);
        check("R1 hit", cmp_hit, 0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        pulse(1, 0, 0); pulse(1, 0, 0); pulse(1, 0, 0); pulse(0, 1, 0);
        rd32(10, v); check("R2 up3 dn1", v, 2);
        pulse(1, 1, 0);
        rd32(10, v); check("R2 both edges hold", v, 2);
    endtask

    task automatic t_latency;
        logic [31:0] v;
        wr(10, 16'd0); wr(11, 16'd0);
        @(negedge clk); up_pin = 1;
        @(negedge clk); @(negedge clk);
        reg_addr = 10; #1 check("R2 not yet after two edges", reg_rdata, 0);
        @(negedge clk); #1 check("R2 counted after third edge", reg_rdata, 1);
        up_pin = 0; repeat (3) @(negedge clk);
        rd32(10, v); check("R2 single step", v, 1);
    endtask

    task automatic t_wrap32;
        logic [31:0] v;
        wr(0, 0);
        wr(10, 16'hFFFF);
        rd32(10, v); check("R6 low word only", v, 32'h0000_FFFF);
        wr(11, 16'h7FFF);
        rd32(10, v); check("R6 high word", v, 32'h7FFF_FFFF);
        pulse(1, 0, 0);
        rd32(10, v); check("R3 up wrap", v, 32'h8000_0000);
        pulse(0, 1, 0);
        rd32(10, v); check("R3 down wrap", v, 32'h7FFF_FFFF);
    endtask

    task automatic t_wrap16;
        logic [31:0] v;
        wr(0, 1); wr(2, 5); wr(3, 0);
        pulse(0, 1, 0);
        rd32(10, v); check("R4 down from 0 to top", v, 4);
        pulse(1, 0, 0);
        rd32(10, v); check("R4 up from top to 0", v, 0);
        wr(10, 9); pulse(1, 0, 0);
        rd32(10, v); check("R4 above top gives 0", v, 0);
        wr(2, 0);
        pulse(1, 0, 0);
        rd32(10, v); check("R4 zero ring holds 0", v, 0);
        wr(3, 2);
        pulse(0, 1, 0);
        rd32(10, v); check("R4 clamp to 65536", v, 65535);
    endtask

    task automatic t_preset;
        logic [31:0] v;
        wr(0, 0); wr(4, 16'h1234); wr(5, 16'hFFFF);
        pulse(0, 0, 1);
        rd32(10, v); check("R5 preset pin", v, 32'hFFFF_1234);
        wr(10, 0); wr(11, 0); wr(1, 16'h0001);
        rd32(10, v); check("R5 preset command", v, 32'hFFFF_1234);
        wr(10, 0); wr(11, 0);
        pulse(1, 0, 1);
        rd32(10, v); check("R5 preset beats up", v, 32'hFFFF_1234);
    endtask

    task automatic t_maxmin;
        logic [31:0] v;
        wr(0, 0);
        repeat (3) pulse(1, 0, 0);
        repeat (5) pulse(0, 1, 0);
        rd32(10, v); check("R7 count", v, 32'hFFFF_FFFE);
        rd32(12, v); check("R7 max", v, 3);
        rd32(14, v); check("R7 min", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_cmp;
        logic [15:0] w;
        wr(0, 0); wr(6, 2); wr(7, 0); wr(8, 5); wr(9, 0);
        pulse(1, 0, 0); pulse(1, 0, 0);
        check("R8 hit A at equal", cmp_hit, 2'b01);
        pulse(1, 0, 0);
        check("R8 hit A sticky", cmp_hit, 2'b01);
        rd(16, w); check("R11 flag word", w, 16'h0001);
        wr(1, 16'h0004);
        check("R9 clear B leaves A", cmp_hit, 2'b01);
        wr(1, 16'h0002);
        check("R9 clear A", cmp_hit, 2'b00);
    endtask

    task automatic t_mode;
        logic [31:0] v; logic [15:0] w;
        wr(6, 77); wr(4, 9); wr(10, 3);
        wr(0, 3);
        rd32(6, v); check("R10 cmpA default", v, 32767);
        rd32(4, v); check("R10 preset default", v, 0);
        rd32(10, v); check("R10 count default", v, 0);
        rd(0, w); check("R10 mode stored", w, 3);
        wr(4, 7); wr(0, 12);
        rd(0, w); check("R10 bad mode ignored", w, 3);
        rd32(4, v); check("R10 bad mode keeps preset", v, 7);
    endtask

    task automatic t_status;
        logic [15:0] w;
        @(negedge clk); dn_pin = 1; pre_pin = 1;
        repeat (3) @(negedge clk);
        rd(17, w); check("R11 pin levels", w, 16'h0006);
        dn_pin = 0; pre_pin = 0;
        repeat (4) @(negedge clk);
        rd(17, w); check("R11 pins low", w, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v; logic [15:0] w;
        wr(0, 0); wr(10, 16'h0042);
        wr(25, 16'hABCD);
        rd(25, w); check("R12 unmapped reads 0", w, 0);
        rd32(10, v); check("R12 count untouched", v, 32'h42);
        rd32(4, v); check("R12 preset untouched", v, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_latency();
        t_wrap32();
        t_wrap16();
        t_preset();
        t_maxmin();
        t_cmp();
        t_mode();
        t_status();
        t_unmapped();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all R): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule